// File: doc/BRIEF.md
# Flash Command Sequencer Controller

This block is a cycle-based behavioural controller for a small NOR-style flash array. A host drives a synchronous bus with active-low chip, write and output enables. Any cycle with chip and write enable low is a write cycle. Any cycle with chip and output enable low and write enable high is a read cycle. Writes never reach the array directly. They feed a command decoder that expects fixed unlock address/data pairs followed by a command byte. Only a complete, correct sequence starts a timed program or erase operation.

Completion can be seen in two ways. The host can watch an active-low busy output, or it can poll status words returned by reads while the operation runs. Four more features are provided:
- a shortened bypass grammar for back-to-back programming;
- a selection window that gathers several sectors into one erase;
- suspend and resume of an erase, so that other sectors can be served in between;
- per-sector protection inputs.

A low-supply input blocks all writes while it is asserted. The reset input aborts everything. Operation lengths are cycle-count parameters, so a bench can poll an operation through to completion.

Top module: `fcs_ctrl`

## Requirements
- R1: While `rst_n` is low and right after its release, `busy_n` is 1, `rdata` is 0 and the controller is in read mode. Every array word then reads as all ones, which is the erased value.
- R2: In read mode, a read cycle to address A places the array word at A on `rdata` one clock later. The value then holds until the next read cycle.
- R3: A program needs four write cycles: 0xAA at UA1 (0x15), 0x55 at UA2 (0x2A), 0xA0 at UA1, then data D at address A. The word at A becomes its old value AND D, so bits only go from 1 to 0.
- R4: A write cycle that does not match the pair expected at its point in a sequence returns the decoder to read mode. The rest of that attempt then has no effect on the array.
- R5: `busy_n` is low for at least PROG_CYC cycles during a program. During an erase it is low for at least WORDS+ERASE_CYC cycles: one preprogram pass over every address zeroes the selected words, then the erase phase runs.
- R6: A read while busy returns a status word instead of data. Bit 7 is the complement of bit 7 of the target data, which is all ones for an erase. Bit 6 inverts on every status read. All other bits are 0.
- R7: 0xAA at UA1, 0x55 at UA2, 0x20 at UA1 enters bypass mode. In bypass, 0xA0 at any address followed by D at A programs. 0x90 then 0x00, each at any address, leaves bypass.
- R8: 0xAA@UA1, 0x55@UA2, 0x80@UA1, 0xAA@UA1, 0x55@UA2, 0x10@UA1 erases every unprotected sector to all ones.
- R9: The same five-cycle prefix followed by 0x30 at an address in sector S selects sector S. The sector index is the top two address bits. Each further 0x30 written within WIN_CYC cycles adds its sector. When the window lapses, only the selected sectors are erased. Any other write during the window cancels the erase.
- R10: 0xB0 at any address during an erase suspends it and `busy_n` returns to 1. While the erase is suspended, unselected sectors read as data and can be programmed with the four-cycle sequence. Selected sectors return status and refuse programs. 0x30 at any address resumes the erase, which then completes.
- R11: A program or erase aimed at a sector whose `prot` bit is 1 leaves its data unchanged. A program to such a sector never drives `busy_n` low, and an erase whose selection is entirely protected never starts.
- R12: While `low_vdd` is 1, write cycles are ignored completely: no sequence advances and no operation starts.
- R13: Pulling `rst_n` low during an operation aborts it. After release, `busy_n` is 1 and the array reads erased.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low; aborts operations and re-erases the model |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address; top SEC_W bits select the sector |
| wdata | input | DATA_W | Write data / command byte (low 8 bits) |
| low_vdd | input | 1 | Low-supply flag, blocks writes while 1 |
| prot | input | 2**SEC_W | Per-sector protection flags |
| rdata | output | DATA_W | Registered read data or status word |
| busy_n | output | 1 | Low while a program or erase runs |

## Verification
The program path is driven by a seeded random mix of three write patterns: complete four-cycle programs, bypass bursts and sequences broken by a wrong address. A bench reference array tells these apart, because only the first two may change memory and a broken sequence must leave it intact. Directed cases cover the remaining rules:
- Status polls check the inverted bit and the toggling bit against the target data.
- A two-sector selection window is tested against a protected-only selection.
- A suspend is used to serve an unselected sector and a refused program, then the erase is resumed.
- Writes are issued under low supply, a reset is applied mid-operation, and a final chip erase must spare the protected sector.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    typedef enum logic [3:0] {
        S_READ, S_U1, S_U2, S_PADDR, S_E1, S_E2, S_E3, S_EWIN,
        S_BYP, S_BYP_P, S_BYP_X, S_PROG, S_PRE, S_ERASE
    } fcs_state_e;

    localparam logic [7:0] C_KEY1   = 8'hAA;
    localparam logic [7:0] C_KEY2   = 8'h55;
    localparam logic [7:0] C_PROG   = 8'hA0;
    localparam logic [7:0] C_ERASE  = 8'h80;
    localparam logic [7:0] C_CHIP   = 8'h10;
    localparam logic [7:0] C_SECT   = 8'h30;
    localparam logic [7:0] C_SUSP   = 8'hB0;
    localparam logic [7:0] C_BYPASS = 8'h20;
    localparam logic [7:0] C_BYPX1  = 8'h90;
    localparam logic [7:0] C_BYPX2  = 8'h00;
endpackage

// File: rtl/fcs_timer.sv
module fcs_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    input  logic         run,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                    cnt_d = len;
        else if (run && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R5: a running count only ever moves towards zero
    assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_q != '0) |=> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/fcs_array.sv
module fcs_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int SEC_W  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [DATA_W-1:0]      rd_data,
    input  logic                   pgm_en,
    input  logic [ADDR_W-1:0]      pgm_addr,
    input  logic [DATA_W-1:0]      pgm_data,
    input  logic                   clr_en,
    input  logic [ADDR_W-1:0]      clr_addr,
    input  logic                   ers_en,
    input  logic [(1<<SEC_W)-1:0]  ers_mask
);
    localparam int WORDS = 1 << ADDR_W;
    localparam int SH    = ADDR_W - SEC_W;

    logic [WORDS-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        for (int i = 0; i < WORDS; i++) begin
            if (ers_en && ers_mask[i >> SH])             mem_d[i] = '1;
            if (clr_en && clr_addr == ADDR_W'(i))        mem_d[i] = '0;
            if (pgm_en && pgm_addr == ADDR_W'(i))        mem_d[i] = mem_q[i] & pgm_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '1;
        else        mem_q <= mem_d;
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
    import fcs_pkg::*;
#(
    parameter int              ADDR_W    = 6,
    parameter int              DATA_W    = 8,
    parameter int              SEC_W     = 2,
    parameter int              PROG_CYC  = 8,
    parameter int              ERASE_CYC = 20,
    parameter int              WIN_CYC   = 6,
    parameter logic [ADDR_W-1:0] UA1     = 6'h15,
    parameter logic [ADDR_W-1:0] UA2     = 6'h2A
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ce_n,
    input  logic                   we_n,
    input  logic                   oe_n,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic                   low_vdd,
    input  logic [(1<<SEC_W)-1:0]  prot,
    output logic [DATA_W-1:0]      rdata,
    output logic                   busy_n
);
    localparam int SECTORS = 1 << SEC_W;
    localparam int WORDS   = 1 << ADDR_W;
    localparam int MAXA    = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int MAXC    = (MAXA > WIN_CYC) ? MAXA : WIN_CYC;
    localparam int CNT_W   = $clog2(MAXC + 1);

    typedef struct packed {
        fcs_state_e          state;
        logic                susp;
        logic                phase;   // 1: suspended inside erase phase
        logic                byp;
        logic [SECTORS-1:0]  mask;
        logic [ADDR_W-1:0]   paddr;
        logic [DATA_W-1:0]   pdata;
        logic [ADDR_W-1:0]   ptr;
        logic                tog;
        logic [DATA_W-1:0]   rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic              wr, rd, busy, status_sel;
    logic [7:0]        cmd;
    logic [SEC_W-1:0]  a_sec;
    logic [SECTORS-1:0] a_bit;
    logic [DATA_W-1:0] arr_rd, status;
    logic              p_load, p_zero, e_load, e_run, e_zero;
    logic [CNT_W-1:0]  e_len;
    logic              pgm_en, clr_en, ers_en;

    assign wr    = !ce_n && !we_n && !low_vdd;
    assign rd    = !ce_n && !oe_n && we_n;
    assign cmd   = wdata[7:0];
    assign a_sec = addr[ADDR_W-1 -: SEC_W];
    assign a_bit = SECTORS'(1) << a_sec;
    assign busy  = (r_q.state == S_PROG) || (r_q.state == S_PRE) || (r_q.state == S_ERASE);
    assign e_run = (r_q.state == S_EWIN) || (r_q.state == S_ERASE);
    assign clr_en = (r_q.state == S_PRE) && r_q.mask[r_q.ptr[ADDR_W-1 -: SEC_W]];

    fcs_timer #(.W(CNT_W)) u_ptmr (
        .clk(clk), .rst_n(rst_n), .load(p_load), .len(CNT_W'(PROG_CYC)),
        .run(1'b1), .zero(p_zero));

    fcs_timer #(.W(CNT_W)) u_etmr (
        .clk(clk), .rst_n(rst_n), .load(e_load), .len(e_len),
        .run(e_run), .zero(e_zero));

    fcs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEC_W(SEC_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .rd_addr(addr), .rd_data(arr_rd),
        .pgm_en(pgm_en), .pgm_addr(r_q.paddr), .pgm_data(r_q.pdata),
        .clr_en(clr_en), .clr_addr(r_q.ptr), .ers_en(ers_en), .ers_mask(r_q.mask));

    always_comb begin
        r_d    = r_q;
        p_load = 1'b0;
        e_load = 1'b0;
        e_len  = CNT_W'(WIN_CYC);
        pgm_en = 1'b0;
        ers_en = 1'b0;
        case (r_q.state)
            S_READ: if (wr) begin
                if (r_q.susp && cmd == C_SECT) begin
                    r_d.susp  = 1'b0;
                    r_d.state = r_q.phase ? S_ERASE : S_PRE;
                end else if (cmd == C_KEY1 && addr == UA1) r_d.state = S_U1;
            end
            S_U1: if (wr) r_d.state = (cmd == C_KEY2 && addr == UA2) ? S_U2 : S_READ;
            S_U2: if (wr) begin
                r_d.state = S_READ;
                if (addr == UA1 && cmd == C_PROG) r_d.state = S_PADDR;
                else if (addr == UA1 && cmd == C_ERASE && !r_q.susp) r_d.state = S_E1;
                else if (addr == UA1 && cmd == C_BYPASS && !r_q.susp) begin
                    r_d.state = S_BYP;
                    r_d.byp   = 1'b1;
                end
            end
            S_PADDR, S_BYP_P: if (wr) begin
                if (prot[a_sec] || (r_q.susp && r_q.mask[a_sec]))
                    r_d.state = r_q.byp ? S_BYP : S_READ;
                else begin
                    r_d.state = S_PROG;
                    r_d.paddr = addr;
                    r_d.pdata = wdata;
                    p_load    = 1'b1;
                end
            end
            S_E1: if (wr) r_d.state = (cmd == C_KEY1 && addr == UA1) ? S_E2 : S_READ;
            S_E2: if (wr) r_d.state = (cmd == C_KEY2 && addr == UA2) ? S_E3 : S_READ;
            S_E3: if (wr) begin
                r_d.state = S_READ;
                r_d.ptr   = '0;
                r_d.phase = 1'b0;
                if (cmd == C_CHIP && addr == UA1) begin
                    r_d.mask  = ~prot;
                    r_d.state = (~prot != '0) ? S_PRE : S_READ;
                end else if (cmd == C_SECT) begin
                    r_d.mask  = a_bit & ~prot;
                    r_d.state = S_EWIN;
                    e_load    = 1'b1;
                end
            end
            S_EWIN: if (wr) begin
                if (cmd == C_SECT) begin
                    r_d.mask = r_q.mask | (a_bit & ~prot);
                    e_load   = 1'b1;
                end else begin
                    r_d.state = S_READ;
                    r_d.mask  = '0;
                end
            end else if (e_zero) r_d.state = (r_q.mask != '0) ? S_PRE : S_READ;
            S_BYP: if (wr) begin
                if (cmd == C_PROG)       r_d.state = S_BYP_P;
                else if (cmd == C_BYPX1) r_d.state = S_BYP_X;
            end
            S_BYP_X: if (wr) begin
                r_d.state = (cmd == C_BYPX2) ? S_READ : S_BYP;
                r_d.byp   = (cmd != C_BYPX2);
            end
            S_PROG: if (p_zero) begin
                pgm_en    = 1'b1;
                r_d.state = r_q.byp ? S_BYP : S_READ;
            end
            S_PRE: if (wr && cmd == C_SUSP) begin
                r_d.susp  = 1'b1;
                r_d.phase = 1'b0;
                r_d.state = S_READ;
            end else if (r_q.ptr == ADDR_W'(WORDS - 1)) begin
                r_d.state = S_ERASE;
                e_load    = 1'b1;
                e_len     = CNT_W'(ERASE_CYC);
            end else r_d.ptr = r_q.ptr + 1'b1;
            S_ERASE: if (wr && cmd == C_SUSP) begin
                r_d.susp  = 1'b1;
                r_d.phase = 1'b1;
                r_d.state = S_READ;
            end else if (e_zero) begin
                ers_en    = 1'b1;
                r_d.state = S_READ;
                r_d.mask  = '0;
            end
            default: r_d.state = S_READ;
        endcase

        status_sel = busy || (r_q.susp && r_q.mask[a_sec]);
        status     = '0;
        status[7]  = (r_q.state == S_PROG) ? ~r_q.pdata[7] : 1'b0;
        status[6]  = r_q.tog;
        if (rd) begin
            r_d.rdata = status_sel ? status : arr_rd;
            r_d.tog   = r_q.tog ^ status_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= S_READ;
        end else r_q <= r_d;
    end

    assign rdata  = r_q.rdata;
    assign busy_n = !busy;

    assert_vdd_block_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (low_vdd && r_q.state inside {S_READ, S_U1, S_U2, S_PADDR, S_E1, S_E2, S_E3,
                                      S_BYP, S_BYP_P, S_BYP_X})
        |=> (r_q.state == $past(r_q.state)));

    assert_prog_prot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_en && $stable(prot)) |-> !prot[r_q.paddr[ADDR_W-1 -: SEC_W]]);

    assert_erase_prot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ers_en && $stable(prot)) |-> ((r_q.mask & prot) == '0));

    assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_n && !wr) |=> (!busy_n || $past(pgm_en) || $past(ers_en)));

    assert_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !busy_n) |=> (rdata[6] == $past(r_q.tog)) && (r_q.tog != $past(r_q.tog)));
endmodule

// File: tb/sim_fcs_ctrl.sv
module sim_fcs_ctrl;
    localparam int PROG_CYC  = 8;
    localparam int ERASE_CYC = 20;
    localparam int WIN_CYC   = 6;
    localparam int WORDS     = 64;
    localparam logic [5:0] UA1 = 6'h15;
    localparam logic [5:0] UA2 = 6'h2A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       low_vdd = 1'b0;
    logic [3:0] prot = '0;
    logic [7:0] rdata;
    logic       busy_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [7:0] model [WORDS];

    fcs_ctrl #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .WIN_CYC(WIN_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .low_vdd(low_vdd), .prot(prot),
        .rdata(rdata), .busy_n(busy_n));

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, act=%0d exp<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic bus_rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; addr = a;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        d = rdata;
    endtask

    task automatic wait_rdy(output int n);
        n = 0;
        while (!busy_n && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic bit sec_blocked(input logic [5:0] a, input logic [3:0] extra);
        return prot[a[5:4]] || extra[a[5:4]];
    endfunction

    task automatic prog4(input logic [5:0] a, input logic [7:0] d, input logic [3:0] extra);
        int n;
        bus_wr(UA1, 8'hAA); bus_wr(UA2, 8'h55); bus_wr(UA1, 8'hA0); bus_wr(a, d);
        wait_rdy(n);
        if (sec_blocked(a, extra)) chk(n == 0, "R11 program to blocked sector ran", n, 0);
        else begin
            chk(n >= PROG_CYC, "R5 program busy length", n, PROG_CYC);
            model[a] = model[a] & d;
        end
    endtask

    task automatic verify_all(input string req);
        logic [7:0] v;
        for (int i = 0; i < WORDS; i++) begin
            bus_rd(6'(i), v);
            chk(v == model[i], req, v, model[i]);
        end
    endtask

    task automatic erase_prefix();
        bus_wr(UA1, 8'hAA); bus_wr(UA2, 8'h55); bus_wr(UA1, 8'h80);
        bus_wr(UA1, 8'hAA); bus_wr(UA2, 8'h55);
    endtask

    initial begin
        logic [7:0] v, s1, s2;
        int n;
        void'($urandom(32'd20240611));
        for (int i = 0; i < WORDS; i++) model[i] = 8'hFF;

        // R1: reset state
        idle(3);
        chk(busy_n == 1'b1, "R1 busy_n during reset", busy_n, 1);
        chk(rdata == 8'h00, "R1 rdata during reset", rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_n == 1'b1, "R1 busy_n after reset", busy_n, 1);
        bus_rd(6'h00, v); chk(v == 8'hFF, "R1 erased word", v, 8'hFF);
        bus_rd(6'h3F, v); chk(v == 8'hFF, "R1 erased word", v, 8'hFF);

        // R3 / R2: directed program, AND behaviour, read latency
        prog4(6'h01, 8'hF0, 4'b0);
        prog4(6'h01, 8'h3C, 4'b0);
        bus_rd(6'h01, v); chk(v == 8'h30, "R3 AND of old and new", v, 8'h30);
        idle(2); chk(rdata == 8'h30, "R2 read data holds", rdata, 8'h30);

        // R6: status while programming (data bit7 = 0 -> status bit7 = 1)
        bus_wr(UA1, 8'hAA); bus_wr(UA2, 8'h55); bus_wr(UA1, 8'hA0); bus_wr(6'h02, 8'h5A);
        bus_rd(6'h02, s1); bus_rd(6'h02, s2);
        chk(s1[7] == 1'b1, "R6 inverted bit7", s1[7], 1);
        chk(s1[6] != s2[6], "R6 toggle bit", s2[6], !s1[6]);
        chk(s1[5:0] == 6'h0, "R6 other status bits zero", s1[5:0], 0);
        wait_rdy(n); model[2] = 8'h5A;
        bus_rd(6'h02, v); chk(v == 8'h5A, "R6 true data after finish", v, 8'h5A);

        // R4: broken sequence (wrong address for second key)
        bus_wr(UA1, 8'hAA); bus_wr(UA1, 8'h55); bus_wr(UA1, 8'hA0); bus_wr(6'h03, 8'h00);
        chk(busy_n == 1'b1, "R4 no operation started", busy_n, 1);
        bus_rd(6'h03, v); chk(v == 8'hFF, "R4 word untouched", v, 8'hFF);

        // R7: bypass mode
        bus_wr(UA1, 8'hAA); bus_wr(UA2, 8'h55); bus_wr(UA1, 8'h20);
        for (int k = 0; k < 3; k++) begin
            bus_wr(6'h00, 8'hA0); bus_wr(6'(8 + k), 8'(8'h81 + k));
            wait_rdy(n);
            chk(n >= PROG_CYC, "R7 bypass program ran", n, PROG_CYC);
            model[8 + k] = 8'(8'h81 + k);
        end
        bus_wr(6'h00, 8'h90); bus_wr(6'h00, 8'h00);
        bus_wr(6'h00, 8'hA0); bus_wr(6'h0C, 8'h00);
        chk(busy_n == 1'b1, "R7 bypass exited", busy_n, 1);
        for (int k = 0; k < 5; k++) begin
            bus_rd(6'(8 + k), v); chk(v == model[8 + k], "R7 bypass data", v, model[8 + k]);
        end

        // R3/R4/R7 random mix
        for (int it = 0; it < 40; it++) begin
            int mode;
            logic [5:0] a;
            logic [7:0] d;
            mode = $urandom_range(0, 2);
            a = 6'($urandom);
            d = 8'($urandom);
            if (mode == 0) prog4(a, d, 4'b0);
            else if (mode == 1) begin
                if (a == UA1) a = 6'h00;
                bus_wr(UA1, 8'hAA); bus_wr(UA1, 8'h55); bus_wr(UA1, 8'hA0); bus_wr(a, d);
                chk(busy_n == 1'b1, "R4 random broken sequence idle", busy_n, 1);
            end else begin
                bus_wr(UA1, 8'hAA); bus_wr(UA2, 8'h55); bus_wr(UA1, 8'h20);
                bus_wr(6'h00, 8'hA0); bus_wr(a, d); wait_rdy(n);
                model[a] = model[a] & d;
                bus_wr(6'h00, 8'h90); bus_wr(6'h00, 8'h00);
            end
        end
        verify_all("R3 random program readback");

        // R12: low supply blocks writes
        low_vdd = 1'b1;
        prog4(6'h07, 8'h00, 4'hF);
        bus_wr(UA1, 8'hAA); bus_wr(UA2, 8'h55);
        low_vdd = 1'b0;
        bus_wr(UA1, 8'hA0); bus_wr(6'h07, 8'h00);
        chk(busy_n == 1'b1, "R12 no operation after blocked keys", busy_n, 1);
        bus_rd(6'h07, v); chk(v == model[7], "R12 word unchanged", v, model[7]);

        // R9: two-sector erase (sectors 1 and 3), R5 erase length, R6 erase status
        prog4(6'h11, 8'h12, 4'b0);
        prog4(6'h31, 8'h34, 4'b0);
        prog4(6'h21, 8'h3C, 4'b0);
        erase_prefix(); bus_wr(6'h10, 8'h30); bus_wr(6'h33, 8'h30);
        idle(WIN_CYC + 2);
        bus_rd(6'h05, s1);
        chk(s1[7] == 1'b0 && s1[5:0] == 6'h0, "R6 erase status word", s1, 0);
        wait_rdy(n);
        chk(n >= WORDS + ERASE_CYC - 4, "R5 erase busy length", n, WORDS + ERASE_CYC);
        for (int i = 16; i < 32; i++) model[i] = 8'hFF;
        for (int i = 48; i < 64; i++) model[i] = 8'hFF;
        verify_all("R9 sector erase result");

        // R11: protection of sector 2
        prot = 4'b0100;
        prog4(6'h21, 8'h00, 4'b0);
        bus_rd(6'h21, v); chk(v == 8'h3C, "R11 protected program", v, 8'h3C);
        erase_prefix(); bus_wr(6'h20, 8'h30);
        idle(WIN_CYC + 6);
        chk(busy_n == 1'b1, "R11 protected erase never busy", busy_n, 1);
        bus_rd(6'h21, v); chk(v == 8'h3C, "R11 protected erase", v, 8'h3C);

        // R10: suspend sector-0 erase, serve sector 1, resume
        prog4(6'h03, 8'h0F, 4'b0);
        erase_prefix(); bus_wr(6'h02, 8'h30);
        idle(20);
        chk(busy_n == 1'b0, "R10 erase running", busy_n, 0);
        bus_wr(6'h00, 8'hB0);
        chk(busy_n == 1'b1, "R10 suspended not busy", busy_n, 1);
        bus_rd(6'h13, v); chk(v == model[19], "R10 read unselected sector", v, model[19]);
        bus_rd(6'h03, v); chk(v[7] == 1'b0 && v[5:0] == 0, "R10 selected sector status", v, 0);
        prog4(6'h13, 8'h66, 4'b0001);
        bus_rd(6'h13, v); chk(v == model[19], "R10 program while suspended", v, model[19]);
        prog4(6'h05, 8'h00, 4'b0001);
        bus_wr(6'h00, 8'h30);
        chk(busy_n == 1'b0, "R10 resumed busy", busy_n, 0);
        wait_rdy(n);
        for (int i = 0; i < 16; i++) model[i] = 8'hFF;
        verify_all("R10 after resume");

        // R8: chip erase spares protected sector 2
        erase_prefix(); bus_wr(UA1, 8'h10);
        wait_rdy(n);
        chk(n >= WORDS + ERASE_CYC, "R5 chip erase busy length", n, WORDS + ERASE_CYC);
        for (int i = 0; i < WORDS; i++) if (i < 32 || i >= 48) model[i] = 8'hFF;
        verify_all("R8 chip erase result");

        // R13: hardware reset aborts a program
        prot = 4'b0;
        bus_wr(UA1, 8'hAA); bus_wr(UA2, 8'h55); bus_wr(UA1, 8'hA0); bus_wr(6'h04, 8'h00);
        chk(busy_n == 1'b0, "R13 program started", busy_n, 0);
        rst_n = 1'b0; idle(2); rst_n = 1'b1; @(negedge clk);
        chk(busy_n == 1'b1, "R13 busy released", busy_n, 1);
        bus_rd(6'h04, v); chk(v == 8'hFF, "R13 array erased after reset", v, 8'hFF);
        bus_rd(6'h21, v); chk(v == 8'hFF, "R13 array erased after reset", v, 8'hFF);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule